// File: doc/BRIEF.md
# Port-Change Interrupt with Bus-Driven Clear

This block watches a parallel input port and asserts an interrupt request whenever the sampled port byte differs from a stored reference value. The request is meant for an open-drain, active-low pin: the block produces a drive-enable, and the pad pulls the pin low while that enable is high. A host can use the pin to learn that input data has changed without polling the serial bus.

The request clears in two ways. The first is that the port returns to the reference value. The second is that the serial slave of this device completes the acknowledge of a transfer addressed to it. That clear happens at the acknowledge clock rise for a read and at the acknowledge clock fall for a write. Every bus clear also loads the present port value into the reference, so that the next difference from that value re-arms the interrupt.

The serial slave supplies three qualifiers: whether the current transfer is addressed to this device, the transfer direction, and single-cycle strobes that mark the two acknowledge edges. The port byte is assumed to be already synchronized to the system clock.

Top module: `port_change_irq`

## Requirements
- R1: After reset the reference holds the value RESET_VAL (all ones by default) and `irq_drive` is 0.
- R2: When no clear strobe is qualified and the port byte differs from the reference in any bit, in either direction, `irq_drive` is 1 after the next rising clock edge.
- R3: When no clear strobe is qualified and the port byte equals the reference, `irq_drive` is 0 after the next rising clock edge, so a port that returns to its reference releases the interrupt without bus activity.
- R4: A clear occurs when `xfer_sel` is 1, `xfer_rd` is 1 (read direction) and `rd_ack_rise` is 1. `irq_drive` is then 0 after the next edge, and the reference takes the port value sampled at that edge.
- R5: A clear occurs when `xfer_sel` is 1, `xfer_rd` is 0 (write direction) and `wr_ack_fall` is 1. It has the same effect on `irq_drive` and on the reference as in R4.
- R6: A strobe for the wrong direction causes no clear and leaves both the reference and `irq_drive` unchanged: `rd_ack_rise` during a write, or `wr_ack_fall` during a read.
- R7: When `xfer_sel` is 0, both strobes are ignored, and the interrupt state and reference are unaffected.
- R8: After a clear, a port value that differs from the newly loaded reference raises `irq_drive` again one edge later. This includes a return to the value the reference held before the clear.
- R9: A port change that is sampled at the same edge as a clear is absorbed into the reference and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | WIDTH | Synchronized port input levels |
| xfer_sel | input | 1 | Current bus transfer is addressed to this device |
| xfer_rd | input | 1 | Transfer direction, 1 = read, 0 = write |
| rd_ack_rise | input | 1 | One-cycle strobe at the read acknowledge clock rise |
| wr_ack_fall | input | 1 | One-cycle strobe at the write acknowledge clock fall |
| irq_drive | output | 1 | 1 = pull the open-drain interrupt pin low |

## Verification
The embedded properties check the following on every cycle:
- A qualified clear drops the request on the next edge and loads the reference with the sampled port byte.
- Without a clear, the reference never moves.
- Without a clear, the request follows the comparison of the port with the reference.

Only the bench scenarios can show the following:
- The clear qualification by direction and by selection works as intended at the pins.
- A change that coincides with a clear is absorbed.
- The comparison covers every bit of every reference value. The bench shows this by sweeping all 256 reference values against every single-bit flip.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
   typedef enum logic {
      XFER_WRITE = 1'b0,
      XFER_READ  = 1'b1
   } xfer_dir_e;

   // qualified clear: the direction selects which acknowledge edge counts
   function automatic logic ack_clear(input logic sel, input xfer_dir_e dir,
                                      input logic rd_rise, input logic wr_fall);
      logic edge_ok;
      edge_ok = (dir == XFER_READ) ? rd_rise : wr_fall;
      return sel & edge_ok;
   endfunction
endpackage

// File: rtl/pcx_clear_ctrl.sv
module pcx_clear_ctrl
   import pcx_pkg::*;
(
   input  logic sel,
   input  logic rd_dir,
   input  logic rd_rise,
   input  logic wr_fall,
   output logic clear
);
   xfer_dir_e dir;

   always_comb begin
      dir   = rd_dir ? XFER_READ : XFER_WRITE;
      clear = ack_clear(sel, dir, rd_rise, wr_fall);
   end
endmodule

// File: rtl/pcx_ref_reg.sv
module pcx_ref_reg #(
   parameter int          WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pcx_ref_reg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_VAL;
      else if (load) q <= d;
   end
endmodule

// File: rtl/pcx_change_det.sv
module pcx_change_det #(
   parameter int WIDTH   = 8,
   parameter bit TREE_OR = 1'b0
) (
   input  logic [WIDTH-1:0] port_val,
   input  logic [WIDTH-1:0] ref_val,
   output logic             differ
);
   localparam int PAIRS = (WIDTH + 1) / 2;

   logic [WIDTH-1:0] bit_diff;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bit_diff[i] = port_val[i] ^ ref_val[i];
   end

   generate
      if (TREE_OR && WIDTH > 1) begin : g_tree
         logic [PAIRS-1:0] pair_diff;
         for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            if (2*p + 1 < WIDTH) begin : g_two
               assign pair_diff[p] = bit_diff[2*p] | bit_diff[2*p+1];
            end else begin : g_one
               assign pair_diff[p] = bit_diff[2*p];
            end
         end
         assign differ = |pair_diff;
      end else begin : g_flat
         assign differ = |bit_diff;
      end
   endgenerate
endmodule

// File: rtl/pcx_irq_flag.sv
module pcx_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic differ,
   output logic drive
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     drive <= 1'b0;
      else if (clear) drive <= 1'b0;
      else            drive <= differ;
   end
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '1,
   parameter bit               TREE_OR   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] port_in,
   input  logic             xfer_sel,
   input  logic             xfer_rd,
   input  logic             rd_ack_rise,
   input  logic             wr_ack_fall,
   output logic             irq_drive
);
   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("port_change_irq: WIDTH out of range 1..64");
      end
   endgenerate

   logic             clear;
   logic             differ;
   logic [WIDTH-1:0] ref_q;

   pcx_clear_ctrl u_clr (
      .sel     (xfer_sel),
      .rd_dir  (xfer_rd),
      .rd_rise (rd_ack_rise),
      .wr_fall (wr_ack_fall),
      .clear   (clear)
   );

   pcx_ref_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (clear),
      .d     (port_in),
      .q     (ref_q)
   );

   pcx_change_det #(.WIDTH(WIDTH), .TREE_OR(TREE_OR)) u_det (
      .port_val (port_in),
      .ref_val  (ref_q),
      .differ   (differ)
   );

   pcx_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clear),
      .differ (differ),
      .drive  (irq_drive)
   );

   // a qualified acknowledge edge releases the pin on the next edge
   assert_clear_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !irq_drive);

   // every clear captures the sampled port byte as the new reference
   assert_ref_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ref_q == $past(port_in)));

   // no clear, no reference movement
   assert_ref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> $stable(ref_q));

   // mismatch without clear raises the request
   assert_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && (port_in != ref_q)) |=> irq_drive);

   // match without clear releases the request
   assert_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && (port_in == ref_q)) |=> !irq_drive);
endmodule

// File: tb/port_change_irq_test.sv
`timescale 1ns/1ps
module port_change_irq_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] port_in = '1;
   logic         xfer_sel = 1'b0;
   logic         xfer_rd = 1'b0;
   logic         rd_ack_rise = 1'b0;
   logic         wr_ack_fall = 1'b0;
   logic         irq_drive;

   int unsigned  n_run = 0;
   int unsigned  n_fail = 0;
   logic [W-1:0] ref_m;

   always #2 clk = ~clk;

   port_change_irq #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .port_in(port_in), .xfer_sel(xfer_sel),
      .xfer_rd(xfer_rd), .rd_ack_rise(rd_ack_rise), .wr_ack_fall(wr_ack_fall),
      .irq_drive(irq_drive)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: irq_drive=%0b expected %0b (port=%02h ref_model=%02h)",
                  req, act, exp, port_in, ref_m);
      end
   endtask

   // one clock: drive at negedge, sample just after posedge; model from requirements
   task automatic step(input logic [W-1:0] p, input logic sel, input logic rd,
                       input logic rr, input logic wf, input string req, input bit do_chk);
      logic clr;
      logic exp;
      @(negedge clk);
      port_in = p; xfer_sel = sel; xfer_rd = rd; rd_ack_rise = rr; wr_ack_fall = wf;
      clr = sel & (rd ? rr : wf);
      exp = clr ? 1'b0 : (p != ref_m);
      if (clr) ref_m = p;
      @(posedge clk);
      #1;
      if (do_chk) check(req, irq_drive, exp);
   endtask

   initial begin : watchdog
      #400000;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin
      ref_m = '1;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", irq_drive, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      step('1, 0, 0, 0, 0, "R1 idle at all-ones", 1);

      // R2/R3: every bit, falling then rising back, against reset reference
      for (int b = 0; b < W; b++) begin
         step(~(8'h01 << b), 0, 0, 0, 0, "R2 falling bit", 1);
         step('1, 0, 0, 0, 0, "R3 return to ref", 1);
      end

      // R4 read clear loads 0x5A, R8 raise on old value
      step(8'h5A, 0, 1, 0, 0, "R2 change", 1);
      step(8'h5A, 1, 1, 1, 0, "R4 read ack clear", 1);
      step(8'h5A, 0, 0, 0, 0, "R4 ref now 5A", 1);
      step('1,   0, 0, 0, 0, "R8 old value raises", 1);

      // R6 wrong-direction strobes ignored
      step('1, 1, 0, 1, 0, "R6 rd strobe in write", 1);
      step(8'h5A, 0, 0, 0, 0, "R6 ref kept at 5A", 1);
      step('1, 1, 1, 0, 1, "R6 wr strobe in read", 1);
      step(8'h5A, 0, 0, 0, 0, "R6 ref kept at 5A (b)", 1);

      // R7 unselected transfer ignored
      step(8'h00, 0, 1, 1, 0, "R7 unselected read", 1);
      step(8'h00, 0, 0, 0, 1, "R7 unselected write", 1);
      step(8'h5A, 0, 0, 0, 0, "R7 ref kept at 5A", 1);

      // R5 write clear
      step(8'hC3, 0, 0, 0, 0, "R2 change to C3", 1);
      step(8'hC3, 1, 0, 0, 1, "R5 write ack clear", 1);
      step(8'hC3, 0, 0, 0, 0, "R5 ref now C3", 1);

      // R9 change coincident with clear is absorbed
      step(8'h3C, 1, 0, 0, 1, "R9 change at clear", 1);
      step(8'h3C, 0, 0, 0, 0, "R9 absorbed", 1);
      step(8'hC3, 0, 0, 0, 0, "R8 reraise after absorb", 1);

      // sweep: every reference value, every single-bit flip
      for (int v = 0; v < 256; v++) begin
         step(v[W-1:0], 1, v[0], v[0], ~v[0], "R4/R5 sweep clear", 1);
         step(v[W-1:0], 0, 0, 0, 0, "R3 sweep match", 1);
         for (int b = 0; b < W; b++) begin
            step(v[W-1:0] ^ (8'h01 << b), 0, 0, 0, 0, "R2 sweep flip", 1);
            step(v[W-1:0], 0, 0, 0, 0, "R3 sweep return", 1);
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule